// File: doc/BRIEF.md
# Event-Sequential Associative Pattern Matcher

This block recognises track candidates by comparing detector hits against a bank of stored patterns. Each stored pattern holds one superstrip code for each detector layer. Every code has a companion mask that marks some bits as don't-care, so one pattern can cover a coarse or a fine region of a layer. Software-side logic loads the bank through a write port while the block is idle.

During an event, hits stream in one per cycle, each with its layer number. Every pattern compares the hit against its own word for that layer. On a match it sets a sticky flag for that layer. The flags build up across the event, so no wide per-event key is ever assembled.

When the event-end strobe arrives, a majority stage counts the matched layers of each pattern against a threshold supplied with the strobe. The patterns that pass become roads. Roads are read out one per accepted transfer in ascending address order, and the final road carries a last flag. New hits and new event ends are held off until the readout completes.

Top module: `am_matcher`

## Requirements
- R1: After reset, road_valid is 0, hit_ready is 1, and every stored layer word and its mask are zero, so a hit with code 0 matches every pattern on its layer.
- R2: A write with wr_en high while the block is idle (no event in progress and no readout) stores wr_val and wr_dc into layer wr_layer of pattern wr_pat.
- R3: A write presented while an event is collecting hits, or during readout, leaves the stored bank unchanged.
- R4: A hit on layer L (L below 6) matches a pattern when every hit bit equals the stored bit, except bits whose mask bit is 1, which are ignored. A match sets that pattern's flag for layer L, and the flag stays set until the event ends. Hits with a layer number of 6 or 7 are ignored.
- R5: At event end, a pattern fires when its number of set layer flags is at least maj_thr, which is sampled in the event-end cycle. A threshold of 0 fires every pattern, and a threshold of 7 fires none.
- R6: A hit accepted in the same cycle as ev_end counts toward that event.
- R7: Fired pattern addresses appear on road_addr in strictly ascending order, one per cycle in which road_valid and road_ready are both high. road_last is high exactly on the final one. After that transfer road_valid drops and hit_ready rises.
- R8: While road_valid is high and road_ready is low, road_valid, road_addr and road_last hold their values.
- R9: hit_ready is low whenever road_valid is high. Hits and ev_end presented then are ignored and affect neither the current nor the next event.
- R10: Event end clears all layer flags, so the next event starts from zero matched layers.
- R11: If no pattern fires, no road is produced and hit_ready is high in the cycle after event end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Bank write strobe |
| wr_pat | input | 7 | Pattern index for write |
| wr_layer | input | 3 | Layer index for write |
| wr_val | input | 12 | Superstrip code to store |
| wr_dc | input | 12 | Don't-care mask to store, 1 = ignore bit |
| hit_valid | input | 1 | Hit present |
| hit_layer | input | 3 | Layer of the hit |
| hit_ss | input | 12 | Superstrip code of the hit |
| ev_end | input | 1 | End-of-event strobe |
| maj_thr | input | 3 | Majority threshold, sampled with ev_end |
| hit_ready | output | 1 | Block accepts hits and event end |
| road_valid | output | 1 | A road address is presented |
| road_ready | input | 1 | Consumer takes the road |
| road_addr | output | 7 | Address of the fired pattern |
| road_last | output | 1 | Final road of the event |

## Verification
The assertions assume that rst_n is asserted from time zero, and that road_ready is the only input that can stall a presented road. Hits and event ends offered during readout must simply be dropped, so the assertions place no limits on them. The stimulus drives every input half a cycle away from the sampling edge. It loads the bank only while idle, except where a write is placed on purpose inside an event or a readout. It also sends hits and event ends during readout on purpose, so that the assertions about holding and ordering roads see those inputs change.

// File: rtl/am_pkg.sv
package am_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_COLLECT = 2'd1,
      ST_DRAIN   = 2'd2
   } am_state_e;

endpackage

// File: rtl/am_pat_cell.sv
module am_pat_cell #(
   parameter int SS_W     = 12,
   parameter int N_LAYERS = 6,
   parameter int LAY_W    = 3,
   parameter int THR_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [LAY_W-1:0] wr_layer,
   input  logic [SS_W-1:0]  wr_val,
   input  logic [SS_W-1:0]  wr_dc,
   input  logic             hit_en,
   input  logic [LAY_W-1:0] hit_layer,
   input  logic [SS_W-1:0]  hit_ss,
   input  logic             clr,
   input  logic [THR_W-1:0] thr,
   output logic             fire
);

   logic [N_LAYERS-1:0] match_q;
   logic [N_LAYERS-1:0] hit_l;
   logic [N_LAYERS-1:0] nxt;
   logic [THR_W-1:0]    cnt;

   for (genvar l = 0; l < N_LAYERS; l++) begin : g_layer
      logic [SS_W-1:0] val_q;
      logic [SS_W-1:0] dc_q;
      logic            eq;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_q <= '0;
            dc_q  <= '0;
         end else if (wr_en && (wr_layer == LAY_W'(l))) begin
            val_q <= wr_val;
            dc_q  <= wr_dc;
         end
      end

      assign eq       = (((hit_ss ^ val_q) & ~dc_q) == '0);
      assign hit_l[l] = hit_en && (hit_layer == LAY_W'(l)) && eq;

      // R4
      sticky_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (match_q[l] && !clr) |=> match_q[l]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   match_q <= '0;
      else if (clr) match_q <= '0;
      else          match_q <= match_q | hit_l;
   end

   assign nxt = match_q | hit_l;

   always_comb begin
      cnt = '0;
      for (int l = 0; l < N_LAYERS; l++) cnt = cnt + THR_W'(nxt[l]);
   end

   assign fire = (cnt >= thr);

   // R10
   cleared_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (match_q == '0));

endmodule

// File: rtl/am_road_pick.sv
module am_road_pick #(
   parameter int N  = 128,
   parameter int AW = 7
) (
   input  logic [N-1:0]  vec,
   output logic [N-1:0]  grant,
   output logic [AW-1:0] idx,
   output logic          last
);

   always_comb begin
      grant = '0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (vec[i]) begin
            grant    = '0;
            grant[i] = 1'b1;
            idx      = AW'(i);
         end
      end
   end

   assign last = ((vec & ~grant) == '0);

endmodule

// File: rtl/am_matcher.sv
module am_matcher #(
   parameter int NUM_PAT  = 128,
   parameter int N_LAYERS = 6,
   parameter int SS_W     = 12,
   localparam int PAT_W   = $clog2(NUM_PAT),
   localparam int LAY_W   = $clog2(N_LAYERS),
   localparam int THR_W   = $clog2(N_LAYERS + 2)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [PAT_W-1:0] wr_pat,
   input  logic [LAY_W-1:0] wr_layer,
   input  logic [SS_W-1:0]  wr_val,
   input  logic [SS_W-1:0]  wr_dc,
   input  logic             hit_valid,
   input  logic [LAY_W-1:0] hit_layer,
   input  logic [SS_W-1:0]  hit_ss,
   input  logic             ev_end,
   input  logic [THR_W-1:0] maj_thr,
   output logic             hit_ready,
   output logic             road_valid,
   input  logic             road_ready,
   output logic [PAT_W-1:0] road_addr,
   output logic             road_last
);
   import am_pkg::*;

   if (NUM_PAT < 2) begin : g_bad_pat
      $error("am_matcher: NUM_PAT must be at least 2");
   end
   if (N_LAYERS < 2) begin : g_bad_lay
      $error("am_matcher: N_LAYERS must be at least 2");
   end
   if (SS_W < 1) begin : g_bad_ss
      $error("am_matcher: SS_W must be at least 1");
   end

   am_state_e          state_q;
   logic [NUM_PAT-1:0] fired_q;
   logic [NUM_PAT-1:0] fire_v;
   logic [NUM_PAT-1:0] grant;
   logic               hit_acc;
   logic               end_acc;
   logic               wr_ok;
   logic               pick_last;
   logic               take;

   assign hit_ready = (state_q != ST_DRAIN);
   assign hit_acc   = hit_valid && hit_ready && (int'(hit_layer) < N_LAYERS);
   assign end_acc   = ev_end && hit_ready;
   assign wr_ok     = wr_en && (state_q == ST_IDLE);

   for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      am_pat_cell #(
         .SS_W     (SS_W),
         .N_LAYERS (N_LAYERS),
         .LAY_W    (LAY_W),
         .THR_W    (THR_W)
      ) u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_en     (wr_ok && (wr_pat == PAT_W'(p))),
         .wr_layer  (wr_layer),
         .wr_val    (wr_val),
         .wr_dc     (wr_dc),
         .hit_en    (hit_acc),
         .hit_layer (hit_layer),
         .hit_ss    (hit_ss),
         .clr       (end_acc),
         .thr       (maj_thr),
         .fire      (fire_v[p])
      );
   end

   am_road_pick #(
      .N  (NUM_PAT),
      .AW (PAT_W)
   ) u_pick (
      .vec   (fired_q),
      .grant (grant),
      .idx   (road_addr),
      .last  (pick_last)
   );

   assign road_valid = (state_q == ST_DRAIN) && (fired_q != '0);
   assign road_last  = road_valid && pick_last;
   assign take       = road_valid && road_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         fired_q <= '0;
      end else begin
         case (state_q)
            ST_IDLE, ST_COLLECT: begin
               if (end_acc) begin
                  fired_q <= fire_v;
                  state_q <= (fire_v != '0) ? ST_DRAIN : ST_IDLE;
               end else if (hit_valid) begin
                  state_q <= ST_COLLECT;
               end
            end
            ST_DRAIN: begin
               if (take) begin
                  fired_q <= fired_q & ~grant;
                  if (pick_last) state_q <= ST_IDLE;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // R7
   one_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant));

   // R8
   road_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (road_valid && !road_ready) |=> (road_valid && $stable(road_addr) && $stable(road_last)));

   // R9
   busy_blocks_hits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      road_valid |-> !hit_ready);

   // R7
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && !road_last) |=> (road_valid && (road_addr > $past(road_addr))));

   // R7
   last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (take && road_last) |=> (!road_valid && hit_ready));

   // R11
   empty_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (end_acc && (fire_v == '0)) |=> (hit_ready && !road_valid));

endmodule

// File: tb/am_matcher_tb.sv
`timescale 1ns/1ps
module am_matcher_tb;
   localparam int NP  = 128;
   localparam int NL  = 6;
   localparam int SSW = 12;
   localparam int PW  = 7;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 0;
   logic [PW-1:0] wr_pat = 0;
   logic [2:0] wr_layer = 0;
   logic [SSW-1:0] wr_val = 0, wr_dc = 0;
   logic hit_valid = 0;
   logic [2:0] hit_layer = 0;
   logic [SSW-1:0] hit_ss = 0;
   logic ev_end = 0;
   logic [2:0] maj_thr = 0;
   logic hit_ready, road_valid, road_last;
   logic road_ready = 0;
   logic [PW-1:0] road_addr;

   int total = 0, bad = 0;
   bit done = 0;

   logic [SSW-1:0] pv [NP][NL];
   logic [SSW-1:0] pd [NP][NL];
   bit [NL-1:0]    mm [NP];

   always #5 clk = ~clk;

   am_matcher u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_pat(wr_pat), .wr_layer(wr_layer),
      .wr_val(wr_val), .wr_dc(wr_dc), .hit_valid(hit_valid), .hit_layer(hit_layer),
      .hit_ss(hit_ss), .ev_end(ev_end), .maj_thr(maj_thr), .hit_ready(hit_ready),
      .road_valid(road_valid), .road_ready(road_ready), .road_addr(road_addr),
      .road_last(road_last)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic bit hit_match(int p, int l, logic [SSW-1:0] ss);
      return (((ss ^ pv[p][l]) & ~pd[p][l]) == '0);
   endfunction

   task automatic model_hit(int l, logic [SSW-1:0] ss);
      if (l < NL)
         for (int p = 0; p < NP; p++)
            if (hit_match(p, l, ss)) mm[p][l] = 1'b1;
   endtask

   // Drives one write cycle; apply says whether the model stores it.
   task automatic write_word(int p, int l, logic [SSW-1:0] v, logic [SSW-1:0] d, bit apply);
      wr_en = 1; wr_pat = PW'(p); wr_layer = 3'(l); wr_val = v; wr_dc = d;
      @(negedge clk);
      wr_en = 0;
      if (apply) begin pv[p][l] = v; pd[p][l] = d; end
   endtask

   task automatic send_hit(int l, logic [SSW-1:0] ss);
      hit_valid = 1; hit_layer = 3'(l); hit_ss = ss;
      @(negedge clk);
      hit_valid = 0;
      model_hit(l, ss);
   endtask

   task automatic drain(input bit [NP-1:0] ev, input bit inject, input string tag);
      bit [NP-1:0] rem;
      bit stalled;
      logic [PW-1:0] held;
      int guard;
      int ea;
      rem = ev; stalled = 0; held = 0; guard = 0;
      if (rem == '0) begin
         chk(road_valid == 0, {tag, " R11 no road"}, road_valid, 0);
         chk(hit_ready == 1, {tag, " R11 ready again"}, hit_ready, 1);
         return;
      end
      while (rem != '0 && guard < 4000) begin
         bit rdy;
         guard++;
         ea = 0;
         for (int i = NP - 1; i >= 0; i--) if (rem[i]) ea = i;
         chk(road_valid == 1, {tag, " R7 valid"}, road_valid, 1);
         chk(road_addr == PW'(ea), {tag, " R7 order"}, road_addr, ea);
         chk(road_last == ((rem & ~(NP'(1) << ea)) == '0), {tag, " R7 last"},
             road_last, ((rem & ~(NP'(1) << ea)) == '0));
         chk(hit_ready == 0, {tag, " R9 ready low"}, hit_ready, 0);
         if (stalled) chk(road_addr == held, {tag, " R8 hold"}, road_addr, held);
         if (inject && guard == 1) begin
            hit_valid = 1; hit_layer = 0; hit_ss = pv[0][0]; ev_end = 1; maj_thr = 0;
         end
         rdy = ($urandom % 3) != 0;
         road_ready = rdy;
         @(negedge clk);
         hit_valid = 0; ev_end = 0;
         if (rdy) begin rem[ea] = 1'b0; stalled = 0; end
         else begin stalled = 1; held = road_addr; end
      end
      road_ready = 0;
      chk(road_valid == 0, {tag, " R7 done"}, road_valid, 0);
      chk(hit_ready == 1, {tag, " R7 ready after"}, hit_ready, 1);
   endtask

   // Event end, optionally with a hit in the same cycle (R6).
   task automatic end_event(int thr, bit with_hit, int l, logic [SSW-1:0] ss,
                            bit inject, input string tag);
      bit [NP-1:0] ev;
      ev_end = 1; maj_thr = 3'(thr);
      if (with_hit) begin hit_valid = 1; hit_layer = 3'(l); hit_ss = ss; end
      @(negedge clk);
      ev_end = 0; hit_valid = 0;
      if (with_hit) model_hit(l, ss);
      for (int p = 0; p < NP; p++) begin
         ev[p] = ($countones(mm[p]) >= thr);
         mm[p] = '0;
      end
      drain(ev, inject, tag);
   endtask

   initial begin
      for (int p = 0; p < NP; p++) begin
         mm[p] = '0;
         for (int l = 0; l < NL; l++) begin pv[p][l] = '0; pd[p][l] = '0; end
      end
      void'($urandom(32'h5eed_0a11));
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);

      // R1: reset state
      chk(road_valid == 0, "R1 road_valid", road_valid, 0);
      chk(hit_ready == 1, "R1 hit_ready", hit_ready, 1);
      end_event(1, 0, 0, 0, 0, "R11 empty");
      end_event(0, 0, 0, 0, 0, "R5 thr0 all");
      send_hit(2, 12'h000);
      end_event(1, 0, 0, 0, 0, "R1 zero bank");

      // R2: load the whole bank with small codes, some bits don't-care
      for (int p = 0; p < NP; p++)
         for (int l = 0; l < NL; l++)
            write_word(p, l, SSW'($urandom % 16),
                       (($urandom % 4) == 0) ? SSW'($urandom % 4) : '0, 1);

      // R4: don't-care bits
      write_word(10, 1, 12'h0F0, 12'h00F, 1);
      send_hit(1, 12'h0F7);
      end_event(1, 0, 0, 0, 0, "R4 dc match");
      send_hit(1, 12'h1F0);
      send_hit(6, 12'h000);
      send_hit(7, 12'h001);
      end_event(1, 0, 0, 0, 0, "R4 cared bit and bad layer");

      // R2 and R6: full pattern, last hit together with event end
      for (int l = 0; l < NL; l++) write_word(20, l, SSW'(12'h800 + l), 12'h000, 1);
      for (int l = 0; l < NL - 1; l++) send_hit(l, SSW'(12'h800 + l));
      end_event(6, 1, NL - 1, SSW'(12'h805), 0, "R6 hit with end");
      for (int l = 0; l < NL; l++) send_hit(l, SSW'(12'h800 + l));
      end_event(7, 0, 0, 0, 0, "R5 thr7 none");

      // R3: writes during collection and during readout are dropped
      write_word(3, 0, 12'h0AA, 12'h000, 1);
      send_hit(2, 12'h900);
      write_word(3, 0, 12'h955, 12'h000, 0);
      end_event(1, 0, 0, 0, 0, "R3 setup");
      send_hit(0, 12'h955);
      end_event(1, 0, 0, 0, 0, "R3 collect write");
      send_hit(0, 12'h0AA);
      ev_end = 1; maj_thr = 1;
      @(negedge clk);
      ev_end = 0;
      model_hit(0, 12'h0AA);
      for (int p = 0; p < NP; p++) mm[p] = '0;
      write_word(3, 1, 12'h977, 12'h000, 0);
      road_ready = 1;
      while (road_valid) @(negedge clk);
      road_ready = 0;
      send_hit(1, 12'h977);
      end_event(1, 0, 0, 0, 0, "R3 readout write");

      // R9: hit and event end during readout are ignored
      send_hit(0, pv[5][0]);
      end_event(1, 0, 0, 0, 1, "R9 inject");
      send_hit(3, 12'hABC);
      end_event(1, 0, 0, 0, 0, "R9 R10 after inject");

      // Random events
      for (int e = 0; e < 40; e++) begin
         int nh;
         int thr;
         nh = 1 + ($urandom % 20);
         thr = (($urandom % 5) == 0) ? ($urandom % 8) : 3 + ($urandom % 3);
         for (int h = 0; h < nh; h++) begin
            int p;
            int l;
            logic [SSW-1:0] ss;
            p = $urandom % NP;
            l = $urandom % 8;
            if (l < NL && ($urandom % 2)) ss = pv[p][l] ^ (SSW'($urandom) & pd[p][l]);
            else ss = SSW'($urandom % 16);
            send_hit(l, ss);
         end
         end_event(thr, ($urandom % 4) == 0, $urandom % NL, SSW'($urandom % 16),
                   ($urandom % 5) == 0, "R5 R10 random");
      end

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule